// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block sits beside a small 8-bit CPU core and decides which maskable interrupt source is serviced next. There are sixteen sources, and each one has three flags: a pending request, a mask and a one-bit priority level. The block also holds the CPU's global interrupt enable flag and an in-service level flag. The winning source is chosen first by programmable level and then by a fixed order based on the source index. The CPU receives a one-cycle acknowledge pulse, a vector address and a two-step stack-push indication. The push writes the status word first and the program counter second.

Acknowledge waits a level-dependent number of clocks. It fires only at an instruction boundary and never while a divide is in progress. When a request is acknowledged, the block clears the global enable flag, copies the winner's level into the in-service flag and clears the winner's request flag. The previous enable and level state is kept on a small internal context stack. A return-from-interrupt strobe restores that state. While a non-maskable handler is running, no maskable request is acknowledged.

Top module: `vint_arbiter`

## Requirements
- R1: After reset all request flags are 0, all mask flags are 1, all level flags are 1, the enable flag is 0, the in-service flag is 1, `ack_o` is 0 and `push_o` is 2'b00.
- R2: A source is considered only when its request flag is 1, its mask flag is 0 and the global enable flag is 1.
- R3: Among the considered sources, level 0 (high) beats level 1 (low), and within one level the lowest index wins. `vec_o` equals VEC_BASE + 2*index of the winner.
- R4: While the in-service flag is 0, level-1 requests are not acknowledged, but level-0 requests still are.
- R5: With `insn_bnd`=1 and `div_busy`=0, `ack_o` rises exactly LAT_HI (7) rising edges after the edge that sets a level-0 request, and LAT_LO (8) edges after the edge that sets a level-1 request. An acknowledge is withheld while `insn_bnd`=0 or `div_busy`=1, and it fires on the edge after both conditions allow it once the wait has elapsed.
- R6: `ack_o` is high for a single cycle. `push_o` is 2'b01 (status word) in that cycle, 2'b10 (program counter) in the next cycle and 2'b00 otherwise.
- R7: In the acknowledge cycle the enable flag reads 0, the in-service flag reads the winner's level and the winner's request flag reads 0.
- R8: A request that cannot be acknowledged stays pending and is acknowledged once the enable, mask, level or blocking condition permits it.
- R9: A `reti_stb` pulse restores the enable and in-service flags to the values they had just before the matching acknowledge. This holds across nesting.
- R10: Software writes use `sw_fld` with 0 = request, 1 = mask, 2 = level, and select the source with `sw_idx`. A hardware request on the same source in the same cycle wins over a software write of 0 to its request flag.
- R11: While `nmi_busy`=1, no acknowledge occurs, even if the enable flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | 16 | Per-source hardware request set pulses |
| sw_we | input | 1 | Software flag write strobe |
| sw_fld | input | 2 | Field select: 0 request, 1 mask, 2 level |
| sw_idx | input | 4 | Source index of the software write |
| sw_val | input | 1 | Bit value written |
| ei_stb | input | 1 | Set the global enable flag |
| di_stb | input | 1 | Clear the global enable flag |
| reti_stb | input | 1 | Return-from-interrupt strobe |
| insn_bnd | input | 1 | CPU is at an instruction boundary |
| div_busy | input | 1 | Divide in progress, which stretches the wait |
| nmi_busy | input | 1 | Non-maskable handler is executing |
| ack_o | output | 1 | One-cycle acknowledge pulse |
| vec_o | output | 16 | Vector address of the acknowledged source |
| push_o | output | 2 | Push step: 01 status word, 10 program counter |
| ie_o | output | 1 | Global enable flag |
| isp_o | output | 1 | In-service level flag |
| req_o | output | 16 | Request flags |

## Verification
The flag outputs (`req_o`, `ie_o`, `isp_o`) change one edge after the strobe that writes them. The bench drives each strobe before a rising edge and samples the flags at the following falling edge. For a request pulse, the bench counts rising edges starting from the edge that latches the request. It requires `ack_o` to be low at edge LAT-1 and high at edge LAT, and it checks `vec_o`, `push_o`, `ie_o`, `isp_o` and `req_o` in that same acknowledge cycle. It then checks the program-counter push step one cycle later. In the stall cases, the bench requires the acknowledge exactly one edge after `div_busy` falls or `insn_bnd` rises. The arbitration sweeps serve each request pattern to exhaustion. After every acknowledge, the bench compares the vector with a winner computed from its own copy of the request, mask and level vectors.

// File: rtl/vint_pkg.sv
package vint_pkg;
  typedef enum logic [1:0] {
    PUSH_IDLE = 2'b00,
    PUSH_PSW  = 2'b01,
    PUSH_PC   = 2'b10
  } push_e;

  typedef enum logic [1:0] {
    FLD_REQ  = 2'd0,
    FLD_MASK = 2'd1,
    FLD_PRIO = 2'd2
  } fld_e;

  typedef struct packed {
    logic ie;
    logic isp;
  } ctx_t;
endpackage

// File: rtl/vint_flags.sv
module vint_flags #(
  parameter int N_SRC = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] hw_req,
  input  logic             sw_we,
  input  logic [1:0]       sw_fld,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic             sw_val,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [N_SRC-1:0] req,
  output logic [N_SRC-1:0] mask,
  output logic [N_SRC-1:0] prio
);
  import vint_pkg::*;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic hit;
    assign hit = sw_we && (sw_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        req[i]  <= 1'b0;
        mask[i] <= 1'b1;
        prio[i] <= 1'b1;
      end else begin
        // hardware set > software write > acknowledge clear
        if (hw_req[i])
          req[i] <= 1'b1;
        else if (hit && sw_fld == FLD_REQ)
          req[i] <= sw_val;
        else if (clr_en && clr_idx == IDX_W'(i))
          req[i] <= 1'b0;
        if (hit && sw_fld == FLD_MASK) mask[i] <= sw_val;
        if (hit && sw_fld == FLD_PRIO) prio[i] <= sw_val;
      end
    end
  end
endmodule

// File: rtl/vint_pick.sv
module vint_pick #(
  parameter int N_SRC = 16,
  parameter int IDX_W = 4
) (
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] mask,
  input  logic [N_SRC-1:0] prio,
  input  logic             isp,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic             lvl
);
  logic [N_SRC-1:0] hi_e, lo_e;

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign hi_e[i] = req[i] & ~mask[i] & ~prio[i];
    assign lo_e[i] = req[i] & ~mask[i] &  prio[i] & isp;
  end

  logic [IDX_W-1:0] hi_idx, lo_idx;

  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (hi_e[i]) hi_idx = IDX_W'(i);
      if (lo_e[i]) lo_idx = IDX_W'(i);
    end
  end

  assign any = (|hi_e) | (|lo_e);
  assign lvl = ~(|hi_e);
  assign idx = lvl ? lo_idx : hi_idx;
endmodule

// File: rtl/vint_wait.sv
module vint_wait #(
  parameter int IDX_W  = 4,
  parameter int LAT_HI = 7,
  parameter int LAT_LO = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ok,
  input  logic [IDX_W-1:0] idx,
  input  logic             lvl,
  output logic             ripe
);
  localparam int CW = $clog2(LAT_LO + 1);
  localparam logic [CW-1:0] MAXC  = CW'(LAT_LO);
  localparam logic [CW-1:0] NEEDH = CW'(LAT_HI - 1);
  localparam logic [CW-1:0] NEEDL = CW'(LAT_LO - 1);

  logic [CW-1:0]    cnt;
  logic             trk_v;
  logic [IDX_W-1:0] trk_idx;
  logic             same;
  logic [CW-1:0]    ec;

  assign same = trk_v && (trk_idx == idx);
  assign ec   = same ? cnt : '0;
  assign ripe = ok && (ec >= (lvl ? NEEDL : NEEDH));

  always_ff @(posedge clk) begin
    if (rst) begin
      trk_v   <= 1'b0;
      trk_idx <= '0;
      cnt     <= '0;
    end else if (!ok) begin
      trk_v <= 1'b0;
      cnt   <= '0;
    end else if (same) begin
      if (cnt != MAXC) cnt <= cnt + 1'b1;
    end else begin
      trk_v   <= 1'b1;
      trk_idx <= idx;
      cnt     <= CW'(1);
    end
  end
endmodule

// File: rtl/vint_ctx.sv
module vint_ctx #(
  parameter int STK_D = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic fire_lvl,
  input  logic reti,
  input  logic ei,
  input  logic di,
  output logic ie,
  output logic isp
);
  import vint_pkg::*;
  localparam int PW = (STK_D > 1) ? $clog2(STK_D) : 1;

  ctx_t          stk [STK_D];
  logic [PW:0]   ptr;
  logic [PW-1:0] wr_i, rd_i;
  logic          full, empty;

  assign full  = (ptr == (PW+1)'(STK_D));
  assign empty = (ptr == '0);
  assign wr_i  = ptr[PW-1:0];
  assign rd_i  = PW'(ptr - 1'b1);

  always_ff @(posedge clk) begin
    if (fire && !reti && !full) stk[wr_i] <= '{ie: ie, isp: isp};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie  <= 1'b0;
      isp <= 1'b1;
      ptr <= '0;
    end else if (reti) begin
      if (!empty) begin
        ie  <= stk[rd_i].ie;
        isp <= stk[rd_i].isp;
        ptr <= ptr - 1'b1;
      end
    end else if (fire) begin
      if (!full) ptr <= ptr + 1'b1;
      ie  <= 1'b0;
      isp <= fire_lvl;
    end else if (ei) begin
      ie <= 1'b1;
    end else if (di) begin
      ie <= 1'b0;
    end
  end
endmodule

// File: rtl/vint_arbiter.sv
module vint_arbiter #(
  parameter int          N_SRC    = 16,
  parameter int          VEC_W    = 16,
  parameter logic [15:0] VEC_BASE = 16'h0004,
  parameter int          LAT_HI   = 7,
  parameter int          LAT_LO   = 8,
  parameter int          STK_D    = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_SRC-1:0]           hw_req,
  input  logic                       sw_we,
  input  logic [1:0]                 sw_fld,
  input  logic [$clog2(N_SRC)-1:0]   sw_idx,
  input  logic                       sw_val,
  input  logic                       ei_stb,
  input  logic                       di_stb,
  input  logic                       reti_stb,
  input  logic                       insn_bnd,
  input  logic                       div_busy,
  input  logic                       nmi_busy,
  output logic                       ack_o,
  output logic [VEC_W-1:0]           vec_o,
  output logic [1:0]                 push_o,
  output logic                       ie_o,
  output logic                       isp_o,
  output logic [N_SRC-1:0]           req_o
);
  import vint_pkg::*;
  localparam int IDX_W = $clog2(N_SRC);

  logic [N_SRC-1:0] req, mask, prio;
  logic             any, lvl, ripe, ok, fire, ie, isp;
  logic [IDX_W-1:0] idx;
  push_e            push_q;

  assign ok   = any && ie && !nmi_busy;
  assign fire = ok && ripe && insn_bnd && !div_busy && !reti_stb;

  vint_flags #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_flags (
    .clk(clk), .rst(rst), .hw_req(hw_req),
    .sw_we(sw_we), .sw_fld(sw_fld), .sw_idx(sw_idx), .sw_val(sw_val),
    .clr_en(fire), .clr_idx(idx),
    .req(req), .mask(mask), .prio(prio)
  );

  vint_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
    .req(req), .mask(mask), .prio(prio), .isp(isp),
    .any(any), .idx(idx), .lvl(lvl)
  );

  vint_wait #(.IDX_W(IDX_W), .LAT_HI(LAT_HI), .LAT_LO(LAT_LO)) u_wait (
    .clk(clk), .rst(rst), .ok(ok), .idx(idx), .lvl(lvl), .ripe(ripe)
  );

  vint_ctx #(.STK_D(STK_D)) u_ctx (
    .clk(clk), .rst(rst), .fire(fire), .fire_lvl(lvl), .reti(reti_stb),
    .ei(ei_stb), .di(di_stb), .ie(ie), .isp(isp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o  <= 1'b0;
      vec_o  <= '0;
      push_q <= PUSH_IDLE;
    end else begin
      ack_o <= fire;
      if (fire) vec_o <= VEC_W'(VEC_BASE) + (VEC_W'(idx) << 1);
      if (fire)                    push_q <= PUSH_PSW;
      else if (push_q == PUSH_PSW) push_q <= PUSH_PC;
      else                         push_q <= PUSH_IDLE;
    end
  end

  assign push_o = push_q;
  assign ie_o   = ie;
  assign isp_o  = isp;
  assign req_o  = req;
endmodule

// File: rtl/vint_arbiter_chk.sv
module vint_arbiter_chk (
  input logic       clk,
  input logic       rst,
  input logic       ack_o,
  input logic [1:0] push_o,
  input logic       ie_o,
  input logic       nmi_busy
);
  // R6: acknowledge is a single-cycle pulse
  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);
  // R6: status word pushed in the acknowledge cycle
  assert_push_psw_R6: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> push_o == 2'b01);
  // R6: program counter pushed in the cycle after
  assert_push_pc_R6: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> push_o == 2'b10);
  // R6: at most one push step at a time
  assert_push_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(push_o));
  // R7: enable flag reads 0 alongside acknowledge
  assert_ie_clear_R7: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> !ie_o);
  // R2: an acknowledge needs the enable flag set beforehand
  assert_need_ie_R2: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(ie_o));
  // R11: no acknowledge decided while a non-maskable handler runs
  assert_nmi_block_R11: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> !$past(nmi_busy));
endmodule

bind vint_arbiter vint_arbiter_chk u_chk (
  .clk(clk), .rst(rst), .ack_o(ack_o), .push_o(push_o),
  .ie_o(ie_o), .nmi_busy(nmi_busy)
);

// File: tb/vint_arbiter_tb.sv
module vint_arbiter_tb;
  localparam int N = 16;
  localparam logic [15:0] BASE = 16'h0004;
  localparam int LH = 7;
  localparam int LL = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] hw_req = '0;
  logic sw_we = 0, sw_val = 0, ei_stb = 0, di_stb = 0, reti_stb = 0;
  logic [1:0] sw_fld = '0;
  logic [3:0] sw_idx = '0;
  logic insn_bnd = 1'b1, div_busy = 1'b0, nmi_busy = 1'b0;
  logic ack_o, ie_o, isp_o;
  logic [15:0] vec_o;
  logic [1:0] push_o;
  logic [N-1:0] req_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vint_arbiter u_dut (
    .clk(clk), .rst(rst), .hw_req(hw_req), .sw_we(sw_we), .sw_fld(sw_fld),
    .sw_idx(sw_idx), .sw_val(sw_val), .ei_stb(ei_stb), .di_stb(di_stb),
    .reti_stb(reti_stb), .insn_bnd(insn_bnd), .div_busy(div_busy),
    .nmi_busy(nmi_busy), .ack_o(ack_o), .vec_o(vec_o), .push_o(push_o),
    .ie_o(ie_o), .isp_o(isp_o), .req_o(req_o)
  );

  task automatic chk(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic sw_wr(input logic [1:0] f, input int i, input logic v);
    sw_we = 1; sw_fld = f; sw_idx = 4'(i); sw_val = v;
    step();
    sw_we = 0;
  endtask

  task automatic p_ei();   ei_stb = 1;   step(); ei_stb = 0;   endtask
  task automatic p_di();   di_stb = 1;   step(); di_stb = 0;   endtask
  task automatic p_reti(); reti_stb = 1; step(); reti_stb = 0; endtask
  task automatic p_hw(input int i); hw_req[i] = 1'b1; step(); hw_req = '0; endtask

  task automatic wait_ack(input int lim, output bit got);
    got = 0;
    for (int k = 0; k < lim && !got; k++) begin
      step();
      if (ack_o) got = 1;
    end
  endtask

  task automatic count_ack(input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      step();
      if (ack_o) c++;
    end
  endtask

  function automatic int model_win(input logic [N-1:0] rq, input logic [N-1:0] mk, input logic [N-1:0] pr);
    for (int i = 0; i < N; i++) if (rq[i] && !mk[i] && !pr[i]) return i;
    for (int i = 0; i < N; i++) if (rq[i] && !mk[i] && pr[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit got;
    int c;
    logic [N-1:0] mrq, mmk, mpr;
    logic [N-1:0] pat_r [3];
    logic [N-1:0] pat_p [3];
    logic [N-1:0] pat_m [3];
    pat_r[0] = 16'hA5C3; pat_p[0] = 16'h0F0F; pat_m[0] = 16'h0000;
    pat_r[1] = 16'hFFFF; pat_p[1] = 16'hFFFF; pat_m[1] = 16'h1001;
    pat_r[2] = 16'h7E18; pat_p[2] = 16'h5A5A; pat_m[2] = 16'h0210;

    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    chk(ie_o == 0, "R1 ie", 32'(ie_o), 0);
    chk(isp_o == 1, "R1 isp", 32'(isp_o), 1);
    chk(ack_o == 0, "R1 ack", 32'(ack_o), 0);
    chk(push_o == 0, "R1 push", 32'(push_o), 0);
    chk(req_o == 0, "R1 req", 32'(req_o), 0);
    // R1 masks at reset: all requests with enable set are never served
    p_ei();
    hw_req = '1; step(); hw_req = '0;
    count_ack(20, c);
    chk(c == 0, "R1 mask reset blocks", 32'(c), 0);
    chk(req_o == '1, "R8 pending kept", 32'(req_o), 32'hFFFF);
    for (int i = 0; i < N; i++) sw_wr(2'd0, i, 1'b0);
    chk(req_o == 0, "R10 sw req clear", 32'(req_o), 0);

    // R10 hardware set beats software clear
    hw_req[3] = 1'b1; sw_we = 1; sw_fld = 2'd0; sw_idx = 4'd3; sw_val = 0;
    step();
    hw_req = '0; sw_we = 0;
    chk(req_o[3] == 1, "R10 hw over sw", 32'(req_o[3]), 1);
    sw_wr(2'd0, 3, 1'b0);
    chk(req_o[3] == 0, "R10 sw write 0", 32'(req_o[3]), 0);

    // R5 latency sweep, every source at both levels
    for (int i = 0; i < N; i++) begin
      for (int p = 0; p < 2; p++) begin
        int lat;
        lat = p ? LL : LH;
        sw_wr(2'd1, i, 1'b0);
        sw_wr(2'd2, i, 1'(p));
        p_hw(i);
        for (int k = 1; k <= lat; k++) begin
          step();
          if (k == lat - 1) chk(ack_o == 0, "R5 early", 32'(ack_o), 0);
          if (k == lat) begin
            chk(ack_o == 1, "R5 on time", 32'(ack_o), 1);
            chk(vec_o == BASE + 16'(2 * i), "R3 vector", 32'(vec_o), 32'(BASE + 16'(2 * i)));
            chk(push_o == 2'b01, "R6 psw step", 32'(push_o), 1);
            chk(ie_o == 0, "R7 ie cleared", 32'(ie_o), 0);
            chk(isp_o == 1'(p), "R7 isp level", 32'(isp_o), 32'(p));
            chk(req_o[i] == 0, "R7 req cleared", 32'(req_o[i]), 0);
          end
        end
        step();
        chk(ack_o == 0, "R6 single pulse", 32'(ack_o), 0);
        chk(push_o == 2'b10, "R6 pc step", 32'(push_o), 2);
        p_reti();
        chk(ie_o == 1 && isp_o == 1, "R9 restore", {30'd0, ie_o, isp_o}, 3);
        sw_wr(2'd1, i, 1'b1);
      end
    end

    // R5 divide stall and boundary stall
    sw_wr(2'd1, 0, 1'b0); sw_wr(2'd2, 0, 1'b0);
    div_busy = 1; p_hw(0);
    count_ack(12, c);
    chk(c == 0, "R5 div stall", 32'(c), 0);
    div_busy = 0; step();
    chk(ack_o == 1, "R5 ack after div", 32'(ack_o), 1);
    step(); p_reti();
    insn_bnd = 0; p_hw(0);
    count_ack(12, c);
    chk(c == 0, "R5 boundary stall", 32'(c), 0);
    insn_bnd = 1; step();
    chk(ack_o == 1, "R5 ack at boundary", 32'(ack_o), 1);
    step(); p_reti();

    // R2 enable flag gates acknowledge
    p_di(); p_hw(0);
    count_ack(20, c);
    chk(c == 0, "R2 enable off", 32'(c), 0);
    p_ei();
    wait_ack(30, got);
    chk(got, "R8 served after enable", 32'(got), 1);
    step(); p_reti();

    // R11 non-maskable handler blocks all
    nmi_busy = 1; p_hw(0);
    count_ack(20, c);
    chk(c == 0, "R11 nmi block", 32'(c), 0);
    nmi_busy = 0;
    wait_ack(30, got);
    chk(got && vec_o == BASE, "R11 served after nmi", 32'(vec_o), 32'(BASE));
    step(); p_reti();
    sw_wr(2'd1, 0, 1'b1);

    // R4 / R9 nesting
    sw_wr(2'd1, 2, 0); sw_wr(2'd2, 2, 0);
    sw_wr(2'd1, 5, 0); sw_wr(2'd2, 5, 1);
    sw_wr(2'd1, 9, 0); sw_wr(2'd2, 9, 0);
    p_hw(2);
    wait_ack(30, got);
    chk(got && vec_o == BASE + 4, "R3 nest first", 32'(vec_o), 32'(BASE + 4));
    step();
    p_ei();
    p_hw(5);
    count_ack(20, c);
    chk(c == 0, "R4 low blocked", 32'(c), 0);
    chk(req_o[5] == 1, "R8 low pending", 32'(req_o[5]), 1);
    p_hw(9);
    wait_ack(30, got);
    chk(got && vec_o == BASE + 18, "R4 high nests", 32'(vec_o), 32'(BASE + 18));
    step();
    p_reti();
    chk(ie_o == 1 && isp_o == 0, "R9 inner restore", {30'd0, ie_o, isp_o}, 2);
    count_ack(20, c);
    chk(c == 0, "R4 still blocked", 32'(c), 0);
    p_reti();
    chk(ie_o == 1 && isp_o == 1, "R9 outer restore", {30'd0, ie_o, isp_o}, 3);
    wait_ack(30, got);
    chk(got && vec_o == BASE + 10 && isp_o == 1, "R8 low served", 32'(vec_o), 32'(BASE + 10));
    step(); p_reti();
    sw_wr(2'd1, 2, 1); sw_wr(2'd1, 5, 1); sw_wr(2'd1, 9, 1);

    // R3 arbitration sweeps
    for (int t = 0; t < 3; t++) begin
      p_di();
      mrq = pat_r[t]; mmk = pat_m[t]; mpr = pat_p[t];
      for (int i = 0; i < N; i++) begin
        sw_wr(2'd1, i, mmk[i]);
        sw_wr(2'd2, i, mpr[i]);
        sw_wr(2'd0, i, mrq[i]);
      end
      p_ei();
      for (int w = model_win(mrq, mmk, mpr); w >= 0; w = model_win(mrq, mmk, mpr)) begin
        wait_ack(40, got);
        chk(got && vec_o == BASE + 16'(2 * w), "R3 winner", 32'(vec_o), 32'(BASE + 16'(2 * w)));
        chk(isp_o == mpr[w], "R7 isp winner", 32'(isp_o), 32'(mpr[w]));
        mrq[w] = 1'b0;
        step(); p_reti();
      end
      count_ack(20, c);
      chk(c == 0, "R2 masked never served", 32'(c), 0);
      chk(req_o == (pat_r[t] & pat_m[t]), "R2 masked pending", 32'(req_o), 32'(pat_r[t] & pat_m[t]));
      for (int i = 0; i < N; i++) begin
        sw_wr(2'd0, i, 1'b0);
        sw_wr(2'd1, i, 1'b1);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule